// File: doc/BRIEF.md
# Preloadable Handshake FIFO Buffer

This block is a synchronous first-in first-out buffer that sits on a streaming channel where data travels forward together with a valid flag and readiness travels backward. A word is taken in on a cycle where the upstream side offers valid data and the buffer signals ready. A word is handed on on a cycle where the buffer offers valid data and the downstream side signals ready. The storage depth is a power of two.

The buffer does not have to start empty. When reset is released it already holds a parameterised number of tokens, with values computed from a base and a step. This lets it seed a feedback loop, such as an accumulator or a ring of stages, with starting values. The upstream ready and the downstream valid come straight from flip-flops. Because of that, several of these buffers can stand in front of stages that join or fork in lock-step without forming a combinational loop.

Top module: `hsfifo_preload`

## Requirements
- R1: While reset is low and right after it is released, out_valid_o is 1 exactly when PRELOAD_N is nonzero, in_ready_o is 1 exactly when PRELOAD_N is below DEPTH, and out_data_o shows the first preloaded token.
- R2: Preloaded token k (k = 0 .. PRELOAD_N-1) has the value (PRELOAD_BASE + k*PRELOAD_STEP) mod 2^DATA_W. The tokens come out in ascending k, ahead of any word written after reset.
- R3: When DEPTH words are held, in_ready_o is 0 and a word offered with in_valid_i high is not stored. It never appears at the output.
- R4: On a cycle where in_valid_i is low, nothing is stored, whatever in_data_i carries.
- R5: While out_valid_o is 1 and out_ready_i is 0, out_valid_o stays 1 and out_data_o stays unchanged on the next cycle.
- R6: Words leave in the order they entered, under any mix of writes, reads and idle cycles. A cycle with both a write and a read leaves the occupancy unchanged.
- R7: in_ready_o equals "occupancy below DEPTH" and out_valid_o equals "occupancy nonzero". Both come from registers and take effect one clock after the transfer that changes the occupancy.
- R8: On a full buffer with out_ready_i and in_valid_i both high, only the read takes place. The occupancy drops by one, and the offered word is not stored.
- R9: The read and write positions wrap modulo DEPTH, so order is kept over streams longer than DEPTH words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low; loads the preload tokens |
| in_valid_i | input | 1 | Upstream offers a word |
| in_data_i | input | DATA_W | Upstream word |
| in_ready_o | output | 1 | Buffer can take a word (registered) |
| out_valid_o | output | 1 | Buffer offers a word (registered) |
| out_data_o | output | DATA_W | Oldest stored word |
| out_ready_i | input | 1 | Downstream takes the offered word |

## Verification
The preloaded tokens are first held under back-pressure and then drained one by one. This separates a correct seed sequence and hold behaviour from a wrong seed value, a wrong seed order, or an output that moves while stalled. A table of mixed write, read and idle cycles is then replayed against a reference queue. This tells correct ordering apart from lost or duplicated words when writes and reads coincide. The buffer is then filled to the brim and offered distinct marker words, both alone and together with a read. Words offered with valid low are also tried. Any of these markers turning up later shows that a full or idle input was wrongly accepted. A long continuous stream runs past several wraps of the positions and exposes errors in the modulo arithmetic.

// File: rtl/hsfifo_pkg.sv
package hsfifo_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_PUSH = 2'b01,
    OP_POP  = 2'b10,
    OP_BOTH = 2'b11
  } hsfifo_op_e;

  function automatic hsfifo_op_e decode_op(input logic push, input logic pop);
    return hsfifo_op_e'({pop, push});
  endfunction

endpackage

// File: rtl/hsfifo_ptr_ctrl.sv
module hsfifo_ptr_ctrl
  import hsfifo_pkg::*;
#(
  parameter int unsigned DEPTH     = 8,
  parameter int unsigned PRELOAD_N = 3,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  input  logic          out_ready_i,
  output logic          push_o,
  output logic [AW-1:0] wr_ptr_o,
  output logic [AW-1:0] rd_ptr_o,
  output logic [CW-1:0] occ_o,
  output logic          in_ready_o,
  output logic          out_valid_o
);

  localparam logic [CW-1:0] OCC_INIT  = CW'(PRELOAD_N);
  localparam logic [CW-1:0] OCC_FULL  = CW'(DEPTH);
  localparam logic [AW-1:0] WPTR_INIT = AW'(PRELOAD_N % DEPTH);

  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] occ_q, occ_d;
  logic          ready_q, valid_q;
  logic          push, pop;
  hsfifo_op_e    op;

  assign push = in_valid_i & ready_q;
  assign pop  = out_ready_i & valid_q;
  assign op   = decode_op(push, pop);

  always_comb begin
    occ_d = occ_q;
    unique case (op)
      OP_PUSH: occ_d = occ_q + 1'b1;
      OP_POP:  occ_d = occ_q - 1'b1;
      default: occ_d = occ_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= WPTR_INIT;
      rd_ptr_q <= '0;
      occ_q    <= OCC_INIT;
      ready_q  <= (PRELOAD_N < DEPTH);
      valid_q  <= (PRELOAD_N != 0);
    end else begin
      if (push) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (pop)  rd_ptr_q <= rd_ptr_q + 1'b1;
      occ_q   <= occ_d;
      ready_q <= (occ_d < OCC_FULL);
      valid_q <= (occ_d != '0);
    end
  end

  assign push_o      = push;
  assign wr_ptr_o    = wr_ptr_q;
  assign rd_ptr_o    = rd_ptr_q;
  assign occ_o       = occ_q;
  assign in_ready_o  = ready_q;
  assign out_valid_o = valid_q;

endmodule

// File: rtl/hsfifo_store.sv
module hsfifo_store #(
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned DEPTH        = 8,
  parameter int unsigned PRELOAD_N    = 3,
  parameter int unsigned PRELOAD_BASE = 32'hA0,
  parameter int unsigned PRELOAD_STEP = 32'h11,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     wr_ptr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     rd_ptr_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] slot_q [DEPTH];

  function automatic logic [DATA_W-1:0] seed_of(input int unsigned k);
    int unsigned v;
    v = PRELOAD_BASE + k * PRELOAD_STEP;
    return DATA_W'(v);
  endfunction

  // reset value per slot: preload token or zero for unused slots
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int unsigned k = 0; k < DEPTH; k++) begin
        slot_q[k] <= (k < PRELOAD_N) ? seed_of(k) : '0;
      end
    end else if (we_i) begin
      slot_q[wr_ptr_i] <= wdata_i;
    end
  end

  assign rdata_o = slot_q[rd_ptr_i];

endmodule

// File: rtl/hsfifo_preload.sv
module hsfifo_preload #(
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned DEPTH        = 8,
  parameter int unsigned PRELOAD_N    = 3,
  parameter int unsigned PRELOAD_BASE = 32'hA0,
  parameter int unsigned PRELOAD_STEP = 32'h11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              in_ready_o,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  input  logic              out_ready_i
);

  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = AW + 1;

  generate
    if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("hsfifo_preload: DEPTH must be a power of two, at least 2");
    end
    if (PRELOAD_N > DEPTH) begin : g_bad_preload
      $error("hsfifo_preload: PRELOAD_N exceeds DEPTH");
    end
  endgenerate

  logic          push;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] occ;

  hsfifo_ptr_ctrl #(
    .DEPTH    (DEPTH),
    .PRELOAD_N(PRELOAD_N)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .out_ready_i(out_ready_i),
    .push_o     (push),
    .wr_ptr_o   (wr_ptr),
    .rd_ptr_o   (rd_ptr),
    .occ_o      (occ),
    .in_ready_o (in_ready_o),
    .out_valid_o(out_valid_o)
  );

  hsfifo_store #(
    .DATA_W      (DATA_W),
    .DEPTH       (DEPTH),
    .PRELOAD_N   (PRELOAD_N),
    .PRELOAD_BASE(PRELOAD_BASE),
    .PRELOAD_STEP(PRELOAD_STEP)
  ) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (push),
    .wr_ptr_i(wr_ptr),
    .wdata_i (in_data_i),
    .rd_ptr_i(rd_ptr),
    .rdata_o (out_data_o)
  );

endmodule

// File: rtl/hsfifo_preload_chk.sv
module hsfifo_preload_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned CW = $clog2(DEPTH) + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic              out_valid_o,
  input logic [DATA_W-1:0] out_data_o,
  input logic              out_ready_i,
  input logic [CW-1:0]     occ_i
);

  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_ready_o) |=> (occ_i <= $past(occ_i)));

  assert_occ_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_i <= FULL);

  assert_idle_input_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_valid_i && !(out_valid_o && out_ready_i)) |=> $stable(occ_i));

  assert_hold_out_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o)));

  assert_both_keep_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o && out_valid_o && out_ready_i) |=> $stable(occ_i));

  assert_valid_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o == (occ_i != '0));

  assert_ready_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o == (occ_i < FULL));

  assert_full_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occ_i == FULL && out_ready_i && in_valid_i) |=> (occ_i == FULL - 1'b1));

endmodule

bind hsfifo_preload hsfifo_preload_chk #(
  .DATA_W(DATA_W),
  .DEPTH (DEPTH)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .in_ready_o (in_ready_o),
  .out_valid_o(out_valid_o),
  .out_data_o (out_data_o),
  .out_ready_i(out_ready_i),
  .occ_i      (occ)
);

// File: tb/sim_hsfifo_preload.sv
`timescale 1ns/1ps
module sim_hsfifo_preload;

  localparam int unsigned DATA_W = 8;
  localparam int unsigned DEPTH  = 8;
  localparam int unsigned PRE_N  = 3;
  localparam int unsigned BASE   = 32'hA0;
  localparam int unsigned STEP   = 32'h11;
  localparam realtime     TCLK   = 20ns;

  // stimulus vector: {in_valid, in_data, out_ready}
  localparam int NVEC = 20;
  localparam logic [9:0] VEC [NVEC] = '{
    {1'b1, 8'h01, 1'b0}, {1'b1, 8'h02, 1'b0}, {1'b1, 8'h03, 1'b1},
    {1'b0, 8'hFF, 1'b1}, {1'b1, 8'h04, 1'b1}, {1'b1, 8'h05, 1'b1},
    {1'b0, 8'h00, 1'b0}, {1'b1, 8'h06, 1'b0}, {1'b0, 8'h77, 1'b1},
    {1'b1, 8'h07, 1'b1}, {1'b1, 8'h08, 1'b0}, {1'b1, 8'h09, 1'b1},
    {1'b0, 8'h00, 1'b1}, {1'b0, 8'h00, 1'b1}, {1'b1, 8'h0A, 1'b1},
    {1'b1, 8'h0B, 1'b0}, {1'b0, 8'h00, 1'b1}, {1'b0, 8'h00, 1'b1},
    {1'b0, 8'h00, 1'b1}, {1'b0, 8'h00, 1'b1}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic [DATA_W-1:0] in_data = '0;
  logic              in_ready;
  logic              out_valid;
  logic [DATA_W-1:0] out_data;
  logic              out_ready = 1'b0;

  int checks = 0;
  int failures = 0;
  logic [DATA_W-1:0] q[$];
  bit                hold_pend = 1'b0;
  logic [DATA_W-1:0] hold_word = '0;

  always #(TCLK/2) clk = ~clk;

  hsfifo_preload #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .PRELOAD_N(PRE_N),
    .PRELOAD_BASE(BASE), .PRELOAD_STEP(STEP)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_ready_o(in_ready),
    .out_valid_o(out_valid), .out_data_o(out_data), .out_ready_i(out_ready)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] seed(input int unsigned k);
    int unsigned v;
    v = BASE + k * STEP;
    return DATA_W'(v);
  endfunction

  // compare outputs with the reference queue at negedge, drive, then update the queue
  task automatic step(input logic iv, input logic [DATA_W-1:0] d, input logic ordy,
                      input string tag);
    bit w, r;
    @(negedge clk);
    chk(out_valid === (q.size() != 0), {tag, " out_valid (R7)"}, out_valid, q.size() != 0);
    chk(in_ready === (q.size() < DEPTH), {tag, " in_ready (R7)"}, in_ready, q.size() < DEPTH);
    if (q.size() != 0) chk(out_data === q[0], {tag, " out_data"}, out_data, q[0]);
    if (hold_pend) chk(out_valid && out_data === hold_word, "R5 held word", out_data, hold_word);
    in_valid  = iv;
    in_data   = d;
    out_ready = ordy;
    w = iv && (q.size() < DEPTH);
    r = ordy && (q.size() != 0);
    hold_pend = (q.size() != 0) && !ordy;
    if (hold_pend) hold_word = q[0];
    @(posedge clk);
    #1;
    if (r) void'(q.pop_front());
    if (w) q.push_back(d);
  endtask

  initial begin
    #(TCLK * 100000);
    failures++;
    checks++;
    $display("FAIL watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int k = 0; k < PRE_N; k++) q.push_back(seed(k));
    // R1: state during reset and just after release
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b1, "R1 out_valid in reset", out_valid, 1);
    chk(in_ready === 1'b1, "R1 in_ready in reset", in_ready, 1);
    rst_n = 1'b1;
    #1;
    chk(out_data === seed(0), "R1 first token", out_data, seed(0));
    chk(out_valid === 1'b1, "R1 out_valid after release", out_valid, 1);

    // R5: stall on the preload head
    step(1'b0, 8'h00, 1'b0, "R5 stall");
    step(1'b0, 8'h00, 1'b0, "R5 stall");
    // R2: drain seed tokens in order, then empty
    for (int k = 0; k < PRE_N; k++) step(1'b0, 8'h00, 1'b1, "R2 seed drain");
    step(1'b0, 8'h00, 1'b1, "R2 empty");

    // R6: table of mixed traffic against the reference queue
    for (int i = 0; i < NVEC; i++) step(VEC[i][9], VEC[i][8:1], VEC[i][0], "R6 table");

    // R4: invalid words never stored
    step(1'b0, 8'h55, 1'b0, "R4 idle");
    step(1'b0, 8'h56, 1'b0, "R4 idle");
    chk(out_valid === 1'b0, "R4 nothing stored", out_valid, 0);

    // R3: fill to full, then offer a marker while full
    for (int i = 0; i < DEPTH; i++) step(1'b1, DATA_W'(8'h30 + i), 1'b0, "R3 fill");
    step(1'b1, 8'hEE, 1'b0, "R3 full offer");
    step(1'b1, 8'hEF, 1'b0, "R3 full offer");
    // R8: full with read and write offered together
    step(1'b1, 8'hDD, 1'b1, "R8 full read+write");
    step(1'b0, 8'h00, 1'b0, "R8 after");
    chk(in_ready === 1'b1, "R8 one slot freed", in_ready, 1);
    // drain fully; markers must not appear
    for (int i = 0; i < DEPTH; i++) step(1'b0, 8'h00, 1'b1, "R3 drain");

    // R9: long stream across several wraps with a pending word
    for (int i = 0; i < 5 * DEPTH; i++) step(1'b1, DATA_W'(i * 7 + 3), (i % 5) != 0, "R9 wrap");
    for (int i = 0; i < DEPTH + 2; i++) step(1'b0, 8'h00, 1'b1, "R9 tail");
    step(1'b0, 8'h00, 1'b1, "R9 empty");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule